// File: doc/BRIEF.md
# Synchronous Pipelined/Flow-Through SRAM

This block is a single-port synchronous SRAM with one bidirectional data bus. Address, chip enables, write controls and write data are sampled on the rising clock edge. A write stores either every byte of the word, or only the bytes whose strobes are active. A static mode input selects the read latency. In flow-through mode the array output goes straight to the bus in the cycle after the read is captured. In pipelined mode the data passes through an output register and appears one cycle later.

Output-enable and sleep act on the bus without waiting for a clock. Deselect takes effect one stage earlier than read data. As soon as a deselect or a write is captured, the bus is released. In pipelined mode this means a read's data is driven only while the command captured after it is also a read. The word is 36 bits wide, split into four 9-bit bytes. The depth is set by the address width. Burst address generation belongs to the surrounding logic.

Top module: `sync_sram_core`

## Requirements
- R1: The device is selected only when chipEn1N=0, chipEn2=1 and chipEn3N=0 at the edge. With any other combination, no write takes place and the captured command counts as a deselect.
- R2: With pipeMode=0 (flow-through), a read captured at edge k drives the word at its address onto dq from edge k until edge k+1.
- R3: With pipeMode=1 (pipelined), a read captured at edge k drives its word on dq from edge k+1 until edge k+2. This happens only if the command captured at edge k+1 is also a read.
- R4: In both modes, a deselect captured at an edge leaves dq at high impedance from that edge until the next one.
- R5: globalWrN=0 on a selected edge writes all four bytes of dq, whatever byteWrN and byteSelN are.
- R6: With globalWrN=1 and byteWrN=0, byte i (dq bits 9i+8 down to 9i) is written only when byteSelN[i]=0, and the other bytes keep their contents. If every byteSelN bit is 1, the command is a read.
- R7: After a write is captured, dq is at high impedance until the next edge.
- R8: outEnN=1 puts dq at high impedance at once, with no clock edge needed.
- R9: sleep=1 puts dq at high impedance at once. Commands at edges while sleep is 1 are ignored. Stored contents survive sleep.
- R10: While rstN=0 and after reset, dq is at high impedance until a read is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | ADDR_W (5) | Word address |
| chipEn1N | input | 1 | Chip enable, active low |
| chipEn2 | input | 1 | Chip enable, active high |
| chipEn3N | input | 1 | Chip enable, active low |
| globalWrN | input | 1 | Write all bytes, active low |
| byteWrN | input | 1 | Byte-write enable, active low |
| byteSelN | input | 4 | Per-byte strobes, active low |
| pipeMode | input | 1 | 1 = pipelined reads, 0 = flow-through; static |
| outEnN | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| dq | inout | 36 | Shared data bus |

## Verification
The hardest case to reach is the pipelined hand-off. Read data from one command appears only if the next captured command is another read. It is cut off when that next command is a deselect, a write or a sleep-masked edge. Random streams weighted toward reads hit these back-to-back pairs and their interruptions often, in both modes with a reset between them. A bench model tracks the captured command, the output register and the array contents. Directed sequences cover byte strobes under a global write, a byte enable with no strobes, each chip-enable polarity failing alone, and writes attempted during sleep.

// File: rtl/sync_sram_pkg.sv
package sync_sram_pkg;
  localparam int NUM_BYTES = 4;

  // strobes from the control half to the storage half
  typedef struct packed {
    logic                 wrEn;
    logic [NUM_BYTES-1:0] byteMask;
    logic                 loadOut;
    logic                 useFlow;
    logic                 driveEn;
  } sramStrobes_t;
endpackage

// File: rtl/sync_sram_ctrl.sv
module sync_sram_ctrl
  import sync_sram_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 chipEn1N,
  input  logic                 chipEn2,
  input  logic                 chipEn3N,
  input  logic                 globalWrN,
  input  logic                 byteWrN,
  input  logic [NUM_BYTES-1:0] byteSelN,
  input  logic                 pipeMode,
  input  logic                 outEnN,
  input  logic                 sleep,
  output sramStrobes_t         strobes
);
  logic                 selNow;
  logic                 wrNow;
  logic                 rdNow;
  logic [NUM_BYTES-1:0] maskNow;
  logic                 rdQ;
  logic                 pipeValidQ;

  always_comb begin
    selNow  = !chipEn1N && chipEn2 && !chipEn3N && !sleep;
    if (!globalWrN)    maskNow = '1;
    else if (!byteWrN) maskNow = ~byteSelN;
    else               maskNow = '0;
    wrNow = selNow && (|maskNow);
    rdNow = selNow && !wrNow;
  end

  // captured read flag plus one extra stage for the output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ        <= 1'b0;
      pipeValidQ <= 1'b0;
    end else begin
      rdQ        <= rdNow;
      pipeValidQ <= rdQ;
    end
  end

  always_comb begin
    strobes.wrEn     = wrNow;
    strobes.byteMask = maskNow;
    strobes.loadOut  = rdQ;
    strobes.useFlow  = !pipeMode;
    // a captured write or deselect clears rdQ, releasing the bus at once
    strobes.driveEn  = !outEnN && !sleep && (pipeMode ? (pipeValidQ && rdQ) : rdQ);
  end
endmodule

// File: rtl/sync_sram_datapath.sv
module sync_sram_datapath
  import sync_sram_pkg::*;
#(
  parameter  int ADDR_W = 5,
  parameter  int BYTE_W = 9,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int DATA_W = NUM_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  sramStrobes_t      strobes,
  output logic [DATA_W-1:0] rdData
);
  logic [ADDR_W-1:0] addrQ;

  always_ff @(posedge clk) addrQ <= addr;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : gBank
    logic [BYTE_W-1:0] bank [DEPTH];
    logic [BYTE_W-1:0] outQ;

    always_ff @(posedge clk) begin
      if (strobes.wrEn && strobes.byteMask[b])
        bank[addr] <= wrData[b*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
      if (strobes.loadOut) outQ <= bank[addrQ];
    end

    assign rdData[b*BYTE_W +: BYTE_W] = strobes.useFlow ? bank[addrQ] : outQ;
  end
endmodule

// File: rtl/sync_sram_core.sv
module sync_sram_core
  import sync_sram_pkg::*;
#(
  parameter  int ADDR_W = 5,
  parameter  int BYTE_W = 9,
  localparam int DATA_W = NUM_BYTES * BYTE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 chipEn1N,
  input  logic                 chipEn2,
  input  logic                 chipEn3N,
  input  logic                 globalWrN,
  input  logic                 byteWrN,
  input  logic [NUM_BYTES-1:0] byteSelN,
  input  logic                 pipeMode,
  input  logic                 outEnN,
  input  logic                 sleep,
  inout  wire  [DATA_W-1:0]    dq
);
  sramStrobes_t      ctlStrobes;
  logic [DATA_W-1:0] rdData;

  sync_sram_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .chipEn1N(chipEn1N), .chipEn2(chipEn2), .chipEn3N(chipEn3N),
    .globalWrN(globalWrN), .byteWrN(byteWrN), .byteSelN(byteSelN), .pipeMode(pipeMode),
    .outEnN(outEnN), .sleep(sleep), .strobes(ctlStrobes)
  );

  sync_sram_datapath #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) i_dpath (
    .clk(clk), .addr(addr), .wrData(dq), .strobes(ctlStrobes), .rdData(rdData)
  );

  assign dq = ctlStrobes.driveEn ? rdData : {DATA_W{1'bz}};
endmodule

// File: rtl/sync_sram_checker.sv
module sync_sram_checker
  import sync_sram_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 chipEn1N,
  input logic                 chipEn2,
  input logic                 chipEn3N,
  input logic                 globalWrN,
  input logic                 byteWrN,
  input logic [NUM_BYTES-1:0] byteSelN,
  input logic                 pipeMode,
  input logic                 outEnN,
  input logic                 sleep,
  input logic                 driveEn
);
  logic chipOn;
  logic writeCmd;
  logic readCmd;

  always_comb begin
    chipOn   = !chipEn1N && chipEn2 && !chipEn3N;
    writeCmd = chipOn && !sleep && (!globalWrN || (!byteWrN && !(&byteSelN)));
    readCmd  = chipOn && !sleep && !writeCmd;
  end

  assert_desel_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    !chipOn |=> !driveEn);

  assert_write_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    writeCmd |=> !driveEn);

  assert_flow_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeMode && readCmd) |=> (driveEn || outEnN || sleep));

  assert_pipe_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pipeMode && readCmd && $past(readCmd)) |=> (driveEn || outEnN || sleep));

  assert_pipe_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pipeMode && !readCmd) |=> !driveEn);
endmodule

bind sync_sram_core sync_sram_checker i_checker (
  .clk(clk), .rstN(rstN), .chipEn1N(chipEn1N), .chipEn2(chipEn2), .chipEn3N(chipEn3N),
  .globalWrN(globalWrN), .byteWrN(byteWrN), .byteSelN(byteSelN), .pipeMode(pipeMode),
  .outEnN(outEnN), .sleep(sleep), .driveEn(ctlStrobes.driveEn)
);

// File: tb/test_sync_sram_core.sv
module test_sync_sram_core;
  localparam int AW = 5;
  localparam int NB = 4;
  localparam int BW = 9;
  localparam int DW = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          chipEn1N = 1'b1, chipEn2 = 1'b0, chipEn3N = 1'b1;
  logic          globalWrN = 1'b1, byteWrN = 1'b1;
  logic [NB-1:0] byteSelN = '1;
  logic          pipeMode = 1'b0, outEnN = 1'b1, sleep = 1'b0;
  logic          tbDrv = 1'b0;
  logic [DW-1:0] tbData = '0;
  wire  [DW-1:0] dq;

  assign dq = tbDrv ? tbData : {DW{1'bz}};

  sync_sram_core i_sync_sram_core (
    .clk(clk), .rstN(rstN), .addr(addr), .chipEn1N(chipEn1N), .chipEn2(chipEn2),
    .chipEn3N(chipEn3N), .globalWrN(globalWrN), .byteWrN(byteWrN), .byteSelN(byteSelN),
    .pipeMode(pipeMode), .outEnN(outEnN), .sleep(sleep), .dq(dq)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  string forceTag = "";

  logic [DW-1:0] mdl [DEPTH];
  logic          mRdQ = 1'b0, mWrQ = 1'b0, mPipeV = 1'b0;
  logic [AW-1:0] mAddrQ = '0;
  logic [DW-1:0] mOut = '0;

  // model of one rising edge, built from the requirements
  task automatic edgeUpdate();
    logic sel;
    logic wr;
    logic [NB-1:0] m;
    if (!rstN) begin
      mRdQ = 1'b0; mWrQ = 1'b0; mPipeV = 1'b0; mAddrQ = addr;
      return;
    end
    if (mRdQ) mOut = mdl[mAddrQ];
    mPipeV = mRdQ;
    sel = !chipEn1N && chipEn2 && !chipEn3N && !sleep;
    m = !globalWrN ? '1 : (!byteWrN ? ~byteSelN : '0);
    wr = sel && (m != '0);
    if (wr)
      for (int b = 0; b < NB; b++)
        if (m[b]) mdl[addr][b*BW +: BW] = tbData[b*BW +: BW];
    mRdQ = sel && !wr;
    mWrQ = wr;
    mAddrQ = addr;
  endtask

  function automatic logic expDrive();
    if (!rstN || outEnN || sleep || mWrQ) return 1'b0;
    return pipeMode ? (mPipeV && mRdQ) : mRdQ;
  endfunction

  function automatic logic [DW-1:0] expBus();
    if (expDrive()) return pipeMode ? mOut : mdl[mAddrQ];
    if (tbDrv) return tbData;
    return {DW{1'bz}};
  endfunction

  function automatic string tagNow();
    if (forceTag != "") return forceTag;
    if (!rstN) return "R10";
    if (sleep) return "R9";
    if (outEnN) return "R8";
    if (mWrQ) return "R7";
    if (!mRdQ) return "R4";
    return pipeMode ? "R3" : "R2";
  endfunction

  task automatic checkBus();
    logic [DW-1:0] e;
    e = expBus();
    vectors++;
    if (dq !== e) begin
      miscompares++;
      $display("FAIL %s t=%0t dq=%h expected=%h", tagNow(), $time, dq, e);
    end
  endtask

  task automatic step();
    @(posedge clk);
    edgeUpdate();
    @(negedge clk);
    checkBus();
  endtask

  task automatic cmdDesel(int which);
    chipEn1N = (which == 0); chipEn2 = (which != 1); chipEn3N = (which == 2);
    globalWrN = 1'b1; byteWrN = 1'b1; byteSelN = '1; tbDrv = 1'b0;
  endtask

  task automatic cmdRead(logic [AW-1:0] a, logic oe);
    addr = a; chipEn1N = 1'b0; chipEn2 = 1'b1; chipEn3N = 1'b0;
    globalWrN = 1'b1; byteWrN = 1'b1; byteSelN = '1; tbDrv = 1'b0; outEnN = oe;
  endtask

  task automatic cmdWrite(logic [AW-1:0] a, logic gw, logic bw, logic [NB-1:0] bs, logic [DW-1:0] d);
    addr = a; chipEn1N = 1'b0; chipEn2 = 1'b1; chipEn3N = 1'b0;
    globalWrN = gw; byteWrN = bw; byteSelN = bs; tbData = d; tbDrv = 1'b1; outEnN = 1'b1;
  endtask

  task automatic randomRun(int n);
    for (int i = 0; i < n; i++) begin
      int r;
      logic [DW-1:0] d;
      r = $urandom % 10;
      d = {$urandom, $urandom};
      sleep = (($urandom % 12) == 0);
      case (r)
        0:       cmdDesel($urandom % 3);
        5:       cmdWrite(AW'($urandom), 1'b0, 1'($urandom), NB'($urandom), d);
        6, 7:    cmdWrite(AW'($urandom), 1'b1, 1'b0, NB'($urandom), d);
        8:       cmdWrite(AW'($urandom), 1'b1, 1'b0, '1, d);
        default: cmdRead(AW'($urandom), (($urandom % 8) == 0));
      endcase
      if (r == 8) begin tbDrv = 1'b0; outEnN = 1'b0; end
      if (r == 0) outEnN = 1'b0;
      step();
    end
    sleep = 1'b0;
  endtask

  task automatic doReset(logic mode);
    cmdDesel(1); outEnN = 1'b0; sleep = 1'b0;
    rstN = 1'b0; pipeMode = mode;
    for (int i = 0; i < 3; i++) step();   // R10: bus released during reset
    rstN = 1'b1;
    step();
  endtask

  task automatic readBack(logic [AW-1:0] a, string tag);
    cmdRead(a, 1'b0); step();
    forceTag = tag;
    if (pipeMode) begin cmdRead(a, 1'b0); step(); end
    forceTag = "";
    cmdDesel(0); step();
  endtask

  initial begin
    void'($urandom(32'h2468ace1));
    doReset(1'b0);
    for (int a = 0; a < DEPTH; a++) begin
      cmdWrite(AW'(a), 1'b0, 1'b1, '1, {$urandom, $urandom}); step();
    end
    for (int a = 0; a < DEPTH; a++) begin cmdRead(AW'(a), 1'b0); step(); end

    // R6: strobes 0 and 2 only, then no strobes acts as read
    cmdWrite(5'd3, 1'b1, 1'b0, 4'b1010, 36'h1_2345_6789); step();
    readBack(5'd3, "R6");
    cmdWrite(5'd3, 1'b1, 1'b0, 4'b1111, 36'hF_FFFF_FFFF); tbDrv = 1'b0; outEnN = 1'b0; step();
    readBack(5'd3, "R6");
    // R5: global write overrides byte controls
    cmdWrite(5'd4, 1'b0, 1'b0, 4'b0101, 36'hA_BCDE_F012); step();
    readBack(5'd4, "R5");
    // R1: each enable failing alone blocks the write
    for (int w = 0; w < 3; w++) begin
      cmdWrite(5'd4, 1'b0, 1'b1, '1, 36'h0_0000_0000);
      chipEn1N = (w == 0); chipEn2 = (w != 1); chipEn3N = (w == 2);
      step();
      readBack(5'd4, "R1");
    end
    // R9: write during sleep ignored, contents kept
    sleep = 1'b1;
    cmdWrite(5'd4, 1'b0, 1'b1, '1, 36'h5_5555_5555); step();
    sleep = 1'b0;
    readBack(5'd4, "R9");
    // R8: outEnN high releases bus on a live read
    cmdRead(5'd7, 1'b1); step(); step();
    randomRun(3000);

    doReset(1'b1);
    readBack(5'd3, "R3");
    cmdWrite(5'd9, 1'b0, 1'b1, '1, 36'h9_0F0F_0F0F); step();
    cmdRead(5'd9, 1'b0); step();
    cmdRead(5'd3, 1'b0); step();
    cmdDesel(2); step();       // R4: data from the last read cut off
    randomRun(3000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule